// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side descriptor engine of an Ethernet MAC. It owns a small two-port descriptor RAM holding a ring of two-word descriptors. Software fills the ring through a word-wide access port and hands each descriptor to the block with the ownership bit of word 0 cleared. The block takes frame bytes from a byte stream that marks the first and last byte of each frame. It copies them byte by byte into the buffer named by the current descriptor through a memory write port. It then hands the descriptor back with its length and frame-boundary flags.

The walk begins at a programmable base index after reset. A descriptor with its wrap bit set sends the walk back to that base. A frame larger than one buffer carries on into the next descriptor. When the block meets a descriptor that software has not yet returned, it drops the frame or the rest of it, pulses an overrun flag and stays on that descriptor.

Top module: `rxd_ring_writer`

## Requirements
- R1: Descriptor word 0 carries the word-aligned buffer address in bits 31:2, the ring-wrap flag in bit 1 and the ownership flag in bit 0. When it hands a descriptor back, the block rewrites word 0 with the same address and wrap bit and with bit 0 set.
- R2: On hand-back, word 1 holds the byte count of that buffer in bits 13:0, start-of-frame in bit 14, end-of-frame in bit 15, and zero in bits 31:16.
- R3: Word 1 of a descriptor is written in the cycle just before word 0 of the same descriptor.
- R4: Each accepted byte is written once, to the buffer base plus its offset within the buffer, in stream order, and only in the cycle it is accepted.
- R5: A buffer holds BUF_UNITS×64 bytes. A frame that fills a buffer without ending continues at offset 0 of the next descriptor. Only the first descriptor of a frame has start-of-frame set, and only the last has end-of-frame set. A frame that ends on the last byte of a buffer uses one descriptor.
- R6: After a descriptor with the wrap flag set is handed back, the next descriptor fetched is the one at the ring base index.
- R7: The first descriptor used after reset is the one at `ring_base`. Descriptors outside the walk are never written.
- R8: If the fetched descriptor already has bit 0 set, nothing is written to it or to memory. The rest of the frame is consumed and discarded, `overrun` pulses for one cycle, and the next frame tries the same descriptor again.
- R9: Bytes that arrive with no start-of-frame marker while no frame is in progress are accepted and discarded.
- R10: `in_ready` is low while a start-of-frame byte waits for its descriptor to be fetched.
- R11: A software write stores a 32-bit word in the descriptor RAM. `sw_rdata` returns the word at `sw_addr` one cycle after the address is presented. Word 2i is word 0 of descriptor i, and word 2i+1 is its word 1.
- R12: During and straight after reset, `overrun` and `mem_we` are low and `in_ready` is high while no start marker is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | $clog2(DESC_NUM) | Index of the first ring descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted at this edge when valid |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | 32 | Buffer byte address |
| mem_data | output | 8 | Buffer byte data |
| sw_we | input | 1 | Software descriptor word write |
| sw_addr | input | $clog2(DESC_NUM)+1 | Software descriptor word index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle after address |
| overrun | output | 1 | One-cycle pulse when a frame hits an owned descriptor |

## Verification
The assertions take for granted that software leaves alone any descriptor the block holds. That means from the fetch of a free descriptor until its word 0 comes back with bit 0 set. They also assume that `ring_base` stays fixed after reset and that every frame ends with an end marker. The stimulus writes descriptors only while the stream is idle and releases a descriptor only after its hand-back has been read. It holds the base at 1 for the whole run and always sends complete frames, so each fetch sees either a free descriptor or one software has not yet returned.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int UNIT_BYTES = 64;
    localparam int LEN_W      = 14;
    localparam int OWN_BIT    = 0;
    localparam int WRAP_BIT   = 1;
    localparam int SOF_BIT    = 14;
    localparam int EOF_BIT    = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_DATA,
        S_DROP,
        S_WB_LEN,
        S_WB_OWN
    } rxd_state_e;
endpackage

// File: rtl/rxd_desc_ram.sv
module rxd_desc_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic [AW-1:0] eng_addr,
    input  logic          eng_we,
    input  logic [31:0]   eng_wdata,
    output logic [31:0]   eng_rdata,
    input  logic [AW-1:0] sw_addr,
    input  logic          sw_we,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata
);
    logic [31:0] words [DEPTH];
    logic [31:0] eng_rdata_q;
    logic [31:0] sw_rdata_q;
    logic        sw_hit_d;

    // engine write wins when both ports target the same word
    always_comb sw_hit_d = sw_we && !(eng_we && (eng_addr == sw_addr));

    always_ff @(posedge clk) begin
        if (eng_we) words[eng_addr] <= eng_wdata;
        if (sw_hit_d) words[sw_addr] <= sw_wdata;
        eng_rdata_q <= words[eng_addr];
        sw_rdata_q  <= words[sw_addr];
    end

    assign eng_rdata = eng_rdata_q;
    assign sw_rdata  = sw_rdata_q;
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
    parameter int DESC_NUM = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] base,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_NUM - 1);

    logic [IDX_W-1:0] idx_d, idx_q;
    logic             started_d, started_q;
    logic [IDX_W-1:0] cur;

    // until the first hand-back the walk sits on the programmed base
    always_comb begin
        cur       = started_q ? idx_q : base;
        idx_d     = cur;
        started_d = started_q;
        if (advance) begin
            started_d = 1'b1;
            if (wrap)                idx_d = base;
            else if (cur == LAST_IDX) idx_d = '0;
            else                     idx_d = cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            started_q <= 1'b0;
        end else begin
            idx_q     <= idx_d;
            started_q <= started_d;
        end
    end

    assign idx = cur;

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) < DESC_NUM));
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int RAM_AW    = 4,
    parameter int BUF_BYTES = 1536,
    parameter int CNT_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_data,
    input  logic [IDX_W-1:0]  idx,
    output logic              ptr_adv,
    output logic              ptr_wrap,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata,
    output logic              overrun
);
    localparam logic [CNT_W-1:0] LAST_OFS = CNT_W'(BUF_BYTES - 1);

    typedef struct packed {
        rxd_state_e       state;
        logic [29:0]      baddr;
        logic             wrap;
        logic [CNT_W-1:0] cnt;
        logic             first;
        logic             eof;
        logic             ovr;
    } eng_t;

    eng_t r_d, r_q;
    logic ram_sel;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        r_d       = r_q;
        r_d.ovr   = 1'b0;
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {r_q.baddr, 2'b00} + 32'(r_q.cnt);
        ram_sel   = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = '0;
        ptr_adv   = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                // stray bytes are swallowed; a start byte waits for its descriptor
                in_ready = !in_sof;
                if (in_valid && in_sof) begin
                    r_d.state = S_FETCH;
                    r_d.first = 1'b1;
                    r_d.cnt   = '0;
                end
            end
            S_FETCH: begin
                r_d.state = S_CHECK;
            end
            S_CHECK: begin
                if (ram_rdata[OWN_BIT]) begin
                    r_d.ovr   = 1'b1;
                    r_d.state = S_DROP;
                end else begin
                    r_d.baddr = ram_rdata[31:2];
                    r_d.wrap  = ram_rdata[WRAP_BIT];
                    r_d.state = S_DATA;
                end
            end
            S_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_we  = 1'b1;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (in_eof) begin
                        r_d.eof   = 1'b1;
                        r_d.state = S_WB_LEN;
                    end else if (r_q.cnt == LAST_OFS) begin
                        r_d.eof   = 1'b0;
                        r_d.state = S_WB_LEN;
                    end
                end
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_eof) r_d.state = S_IDLE;
            end
            S_WB_LEN: begin
                ram_sel   = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = '0;
                ram_wdata[LEN_W-1:0] = LEN_W'(r_q.cnt);
                ram_wdata[SOF_BIT]   = r_q.first;
                ram_wdata[EOF_BIT]   = r_q.eof;
                r_d.state = S_WB_OWN;
            end
            S_WB_OWN: begin
                ram_we    = 1'b1;
                ram_wdata = {r_q.baddr, r_q.wrap, 1'b1};
                ptr_adv   = 1'b1;
                if (r_q.eof) begin
                    r_d.state = S_IDLE;
                end else begin
                    r_d.state = S_FETCH;
                    r_d.first = 1'b0;
                    r_d.cnt   = '0;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, baddr: '0, wrap: 1'b0, cnt: '0,
                     first: 1'b0, eof: 1'b0, ovr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ram_addr = {idx, ram_sel};
    assign ptr_wrap = r_q.wrap;
    assign mem_data = in_data;
    assign overrun  = r_q.ovr;
    assign cnt_q    = r_q.cnt;

    assert_word_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_addr[0]) |->
            ($past(ram_we) && ($past(ram_addr) == {ram_addr[RAM_AW-1:1], 1'b1})));

    assert_buf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(cnt_q) < BUF_BYTES));

    assert_ovr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (!mem_we && !ram_we));

    assert_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_valid && in_ready));
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
    parameter int DESC_NUM  = 8,
    parameter int BUF_UNITS = 24,
    parameter int IDX_W     = $clog2(DESC_NUM),
    parameter int RAM_AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_data,
    input  logic              sw_we,
    input  logic [RAM_AW-1:0] sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    output logic              overrun
);
    localparam int BUF_BYTES = BUF_UNITS * rxd_pkg::UNIT_BYTES;
    localparam int CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int RAM_DEPTH = 2 * DESC_NUM;

    logic [IDX_W-1:0]  idx;
    logic              ptr_adv;
    logic              ptr_wrap;
    logic [RAM_AW-1:0] ram_addr;
    logic              ram_we;
    logic [31:0]       ram_wdata;
    logic [31:0]       ram_rdata;

    rxd_ring_ptr #(.DESC_NUM(DESC_NUM), .IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (ring_base),
        .advance (ptr_adv),
        .wrap    (ptr_wrap),
        .idx     (idx)
    );

    rxd_desc_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
        .clk       (clk),
        .eng_addr  (ram_addr),
        .eng_we    (ram_we),
        .eng_wdata (ram_wdata),
        .eng_rdata (ram_rdata),
        .sw_addr   (sw_addr),
        .sw_we     (sw_we),
        .sw_wdata  (sw_wdata),
        .sw_rdata  (sw_rdata)
    );

    rxd_engine #(
        .IDX_W     (IDX_W),
        .RAM_AW    (RAM_AW),
        .BUF_BYTES (BUF_BYTES),
        .CNT_W     (CNT_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .idx       (idx),
        .ptr_adv   (ptr_adv),
        .ptr_wrap  (ptr_wrap),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .overrun   (overrun)
    );
endmodule

// File: tb/sim_rxd_ring_writer.sv
module sim_rxd_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int NDESC      = 4;
    localparam int BUFB       = 64;
    localparam logic [31:0] BUFBASE = 32'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ring_base = 2'd1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_ready;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        overrun;

    int nchk = 0;
    int nerr = 0;
    int wr_cnt = 0;
    int ovr_cnt = 0;
    int stray_cnt = 0;
    logic [7:0] bmem [256];
    logic [31:0] ofs;

    rxd_ring_writer #(.DESC_NUM(NDESC), .BUF_UNITS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ofs = mem_addr - BUFBASE;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                if (mem_addr >= BUFBASE && mem_addr < BUFBASE + 32'd256)
                    bmem[ofs[7:0]] <= mem_data;
                else
                    stray_cnt <= stray_cnt + 1;
            end
            if (overrun) ovr_cnt <= ovr_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(int id, int i);
        return 8'((id * 37 + i * 3 + 1) & 255);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic sw_wr(int a, logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 3'(a); sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_rd(int a, output logic [31:0] d);
        @(negedge clk);
        sw_addr = 3'(a);
        @(posedge clk);
        #1;
        d = sw_rdata;
    endtask

    task automatic send(int id, int n, output logic first_ready);
        first_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pat(id, i);
            in_sof = (i == 0); in_eof = (i == n - 1);
            #1;
            if (i == 0) first_ready = in_ready;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic buf_chk(string req, int id, int desc, int from, int n);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (bmem[desc * BUFB + k] !== pat(id, from + k)) bad++;
        chk(req, "buffer bytes wrong", bad, 0);
    endtask

    task automatic desc_chk(string req, int desc, logic [31:0] w0, logic [31:0] w1);
        logic [31:0] d;
        sw_rd(2 * desc + 1, d);
        chk(req, $sformatf("desc%0d word1", desc), d, w1);
        sw_rd(2 * desc, d);
        chk(req, $sformatf("desc%0d word0", desc), d, w0);
    endtask

    function automatic logic [31:0] a0(int desc);
        return BUFBASE + 32'(desc * BUFB);
    endfunction

    initial begin
        repeat (CLK_PERIOD * 5000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic fr;
        logic [31:0] d;
        int w0c;
        int ov0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "overrun in reset", overrun, 0);
        chk("R12", "mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R12", "overrun after reset", overrun, 0);
        chk("R12", "in_ready after reset", in_ready, 1);

        for (int i = 0; i < NDESC; i++) begin
            sw_wr(2 * i, a0(i) | ((i == NDESC - 1) ? 32'h2 : 32'h0));
            sw_wr(2 * i + 1, 32'hF000_0000);
        end
        // R11 software read back
        sw_rd(6, d);
        chk("R11", "sw read desc3 word0", d, 32'h4C2);
        sw_rd(1, d);
        chk("R11", "sw read desc0 word1", d, 32'hF000_0000);

        // R9 stray bytes while idle
        w0c = wr_cnt;
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hAA;
        #1;
        chk("R9", "in_ready for stray byte", in_ready, 1);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "writes from stray bytes", wr_cnt - w0c, 0);

        // frame A: 10 bytes into desc1 (base)
        w0c = wr_cnt;
        send(1, 10, fr);
        chk("R10", "in_ready on waiting sof", fr, 0);
        chk("R4", "write count frame A", wr_cnt - w0c, 10);
        desc_chk("R1 R2 R7", 1, a0(1) | 32'h1, 32'h0000_C00A);
        buf_chk("R4", 1, 1, 0, 10);

        // frame B: exactly one buffer into desc2
        send(2, 64, fr);
        desc_chk("R5", 2, a0(2) | 32'h1, 32'h0000_C040);
        buf_chk("R5", 2, 2, 0, 64);

        // release desc1; frame C spans desc3 (wrap) and desc1
        sw_wr(2, a0(1));
        send(3, 100, fr);
        desc_chk("R5", 3, a0(3) | 32'h3, 32'h0000_4040);
        desc_chk("R6", 1, a0(1) | 32'h1, 32'h0000_8024);
        buf_chk("R5", 3, 3, 0, 64);
        buf_chk("R6", 3, 1, 64, 36);

        // frame D hits desc2 still owned
        w0c = wr_cnt; ov0 = ovr_cnt;
        send(4, 8, fr);
        chk("R8", "overrun pulses frame D", ovr_cnt - ov0, 1);
        chk("R8", "writes frame D", wr_cnt - w0c, 0);
        desc_chk("R8", 2, a0(2) | 32'h1, 32'h0000_C040);

        // release desc2 and desc3; frame E retries desc2
        sw_wr(4, a0(2));
        sw_wr(6, a0(3) | 32'h2);
        send(5, 5, fr);
        desc_chk("R8", 2, a0(2) | 32'h1, 32'h0000_C005);
        buf_chk("R8", 5, 2, 0, 5);

        // frame F: desc3 fills, continuation meets owned desc1
        w0c = wr_cnt; ov0 = ovr_cnt;
        send(6, 70, fr);
        chk("R8", "writes frame F", wr_cnt - w0c, 64);
        chk("R8", "overrun pulses frame F", ovr_cnt - ov0, 1);
        desc_chk("R5", 3, a0(3) | 32'h3, 32'h0000_4040);
        desc_chk("R8", 1, a0(1) | 32'h1, 32'h0000_8024);

        // release desc1; frame G lands there
        sw_wr(2, a0(1));
        send(7, 3, fr);
        desc_chk("R6", 1, a0(1) | 32'h1, 32'h0000_C003);
        buf_chk("R4", 7, 1, 0, 3);

        // R7 descriptor 0 lies outside the walk
        desc_chk("R7", 0, a0(0), 32'hF000_0000);
        chk("R4", "writes outside buffers", stray_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule